// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives a 16x oversampling clock enable for a UART receiver and transmitter from a 48 MHz reference clock. Software supplies a divisor that has a 14-bit integer part and a 3-bit fraction counted in eighths. The block raises a one-cycle `tick` each time the programmed number of reference cycles has passed. The average tick rate is therefore 48 MHz divided by (integer + fraction/8), and the baud rate is one sixteenth of that. An integer of 1 with a zero fraction gives 3 Mbaud. An integer of 16383 gives about 183 baud.

The fraction is built from whole reference cycles. A 3-bit phase accumulator adds the fraction once per tick period. Each time the accumulator wraps, that period is one reference cycle longer. Over any eight consecutive periods, exactly "fraction" of them are stretched. The first divisor written after reset starts the generator at once. A divisor written while the generator runs is held until the next tick and then replaces the old one, so no period is cut short.

Top module: `fracBaudGen`

## Requirements
- R1: While reset is asserted, and after reset until the first divisor write, `tick` and `divValid` are both 0.
- R2: A write (`divWe`=1 at a rising edge) while idle starts the generator. `divValid` is 1 from the next cycle on. The first `tick` is high during the N-th clock cycle after the write edge, where N is the effective integer part.
- R3: With fraction 0, ticks are spaced exactly N cycles apart and each lasts one cycle. With N=1, `tick` stays high on every cycle.
- R4: `divFrac` (3 bits) gives F eighths. Counting the periods after the first tick as k=1,2,…, period k lasts N+1 cycles when floor(k·F/8) > floor((k-1)·F/8), and N cycles otherwise. Over each group of eight periods, exactly F periods are stretched.
- R5: An integer part (`divInt`, 14 bits) of 0 acts exactly like 1.
- R6: A write while running does not change the period that is in progress. The new divisor starts at the next tick. The period after that tick lasts N' cycles, and the fractional phase starts again from zero.
- R7: The largest integer, 16383, gives ticks exactly 16383 cycles apart.
- R8: If several writes arrive before the next tick, only the last one is applied.
- R9: Once set, `divValid` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWe | input | 1 | Divisor write strobe |
| divInt | input | 14 | Integer part of the divisor (0 treated as 1) |
| divFrac | input | 3 | Fractional part of the divisor in eighths |
| tick | output | 1 | One-cycle 16x-baud clock enable |
| divValid | output | 1 | A divisor has been applied and ticks are running |

## Verification
Integer-only divisors of 1, 7 and 16383 check that the spacing is exact and show the difference between a single-cycle pulse and a continuously high enable. Fractions of 3/8 and 7/8 over more than eight periods show exactly which periods get the extra cycle. A sparse pattern and a nearly full pattern together catch an accumulator that overflows on the wrong phase. A zero integer is compared with the same run using 1. Writes that arrive mid-period, including two writes in a row, show whether the switch happens at the tick boundary, whether the last write wins, and whether the fractional phase restarts.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic start;   // load a fresh period, clear fractional phase
    logic reload;  // next period with the same divisor
  } fbgStrobe_t;
endpackage

// File: rtl/fbg_datapath.sv
module fbg_datapath
  import fbg_pkg::*;
#(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbgStrobe_t        strb,
  input  logic [INT_W-1:0]  perInt,
  input  logic [FRAC_W-1:0] perFrac,
  output logic              zeroHit
);
  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   accSum;
  logic              carry;
  logic [INT_W-1:0]  lenM1;

  assign accSum  = {1'b0, acc} + {1'b0, perFrac};
  assign carry   = accSum[FRAC_W];
  assign lenM1   = perInt - INT_W'(1) + INT_W'(carry);
  assign zeroHit = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      acc <= '0;
    end else if (strb.start) begin
      cnt <= perInt - INT_W'(1);
      acc <= '0;
    end else if (strb.reload) begin
      cnt <= lenM1;
      acc <= accSum[FRAC_W-1:0];
    end else if (cnt != '0) begin
      cnt <= cnt - INT_W'(1);
    end
  end

  // R3: between strobes the counter only steps down by one
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && !strb.start && !strb.reload) |=> (cnt == $past(cnt) - INT_W'(1)));

  // R6: a fresh start always begins at phase zero
  p_start_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (acc == '0));
endmodule

// File: rtl/fbg_control.sv
module fbg_control
  import fbg_pkg::*;
#(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              divWe,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic              zeroHit,
  output fbgStrobe_t        strb,
  output logic [INT_W-1:0]  selInt,
  output logic [FRAC_W-1:0] selFrac,
  output logic              tick,
  output logic              divValid
);
  logic              running;
  logic              pendFlag;
  logic [INT_W-1:0]  pendInt, actInt, inInt;
  logic [FRAC_W-1:0] pendFrac, actFrac;
  logic              apply, swap;

  assign inInt    = (divInt == '0) ? INT_W'(1) : divInt;
  assign tick     = running && zeroHit;
  assign apply    = divWe && !running;
  assign swap     = tick && pendFlag;
  assign divValid = running;

  always_comb begin
    if (apply) begin
      selInt  = inInt;
      selFrac = divFrac;
    end else if (pendFlag) begin
      selInt  = pendInt;
      selFrac = pendFrac;
    end else begin
      selInt  = actInt;
      selFrac = actFrac;
    end
    strb.start  = apply || swap;
    strb.reload = tick && !pendFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      pendFlag <= 1'b0;
      pendInt  <= INT_W'(1);
      pendFrac <= '0;
      actInt   <= INT_W'(1);
      actFrac  <= '0;
    end else begin
      if (apply) begin
        running <= 1'b1;
        actInt  <= inInt;
        actFrac <= divFrac;
      end
      if (swap) begin
        actInt   <= pendInt;
        actFrac  <= pendFrac;
        pendFlag <= 1'b0;
      end
      if (divWe && running) begin
        pendInt  <= inInt;
        pendFrac <= divFrac;
        pendFlag <= 1'b1;
      end
    end
  end

  // R9: valid flag never drops outside reset
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    divValid |=> divValid);

  // R3: a reload only happens when the datapath count is exhausted
  p_reload_at_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |-> zeroHit);

  // R6: a pending divisor is consumed at the tick
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && pendFlag && !divWe) |=> !pendFlag);

  // R5: an integer of zero never becomes active
  p_act_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (actInt != '0));
endmodule

// File: rtl/fracBaudGen.sv
module fracBaudGen
  import fbg_pkg::*;
#(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              divWe,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic              tick,
  output logic              divValid
);
  fbgStrobe_t        strb;
  logic [INT_W-1:0]  selInt;
  logic [FRAC_W-1:0] selFrac;
  logic              zeroHit;

  fbg_control #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .divWe(divWe), .divInt(divInt), .divFrac(divFrac),
    .zeroHit(zeroHit), .strb(strb), .selInt(selInt), .selFrac(selFrac),
    .tick(tick), .divValid(divValid)
  );

  fbg_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .perInt(selInt), .perFrac(selFrac),
    .zeroHit(zeroHit)
  );

  // R1: nothing ticks before a divisor is valid
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !divValid |-> !tick);
endmodule

// File: tb/sim_fracBaudGen.sv
module sim_fracBaudGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        divWe = 1'b0;
  logic [13:0] divInt = '0;
  logic [2:0]  divFrac = '0;
  logic        tick, divValid;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int tk[64];
  int nTk = 0;
  bit rec = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  fracBaudGen u0 (.clk(clk), .rstN(rstN), .divWe(divWe), .divInt(divInt),
                  .divFrac(divFrac), .tick(tick), .divValid(divValid));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rec && tick && nTk < 64) begin
      tk[nTk] = cyc;
      nTk++;
    end

  always @(posedge clk)
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected<=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rec = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    divWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nTk = 0;
  endtask

  function automatic int extra(input int k, input int f);
    if (k == 0) return 0;
    return (k * f) / 8 - ((k - 1) * f) / 8;
  endfunction

  task automatic writeDiv(input int wi, input int wf);
    divInt = 14'(wi);
    divFrac = 3'(wf);
    divWe = 1'b1;
    @(negedge clk);
    divWe = 1'b0;
  endtask

  // R1: quiet during and after reset
  task automatic testReset();
    doReset();
    rec = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(tick == 1'b0, "R1 tick idle", int'(tick), 0);
    end
    chk(divValid == 1'b0, "R1 valid idle", int'(divValid), 0);
    chk(nTk == 0, "R1 no ticks", nTk, 0);
  endtask

  // R2/R3/R4/R5/R7: start from idle and compare tick times
  task automatic runScenario(input int wi, input int wf, input int effN,
                             input int nT, input string tag);
    int wrCyc, t, guard;
    doReset();
    rec = 1'b1;
    writeDiv(wi, wf);
    wrCyc = cyc;
    chk(divValid == 1'b1, "R2 valid after write", int'(divValid), 1);
    guard = 0;
    while (nTk < nT && guard < effN * (nT + 2) + 20) begin
      @(negedge clk);
      guard++;
    end
    chk(nTk >= nT, tag, nTk, nT);
    t = wrCyc - 1;
    for (int k = 0; k < nT; k++) begin
      t += effN + extra(k, wf);
      chk(tk[k] == t, tag, tk[k], t);
    end
    chk(divValid == 1'b1, "R9 valid held", int'(divValid), 1);
  endtask

  // R6/R8: mid-period rewrite, optionally two writes in a row
  task automatic testSwitch(input bit twoWrites);
    int wrCyc, t;
    doReset();
    rec = 1'b1;
    writeDiv(5, 0);
    wrCyc = cyc;
    repeat (6) @(negedge clk);           // cyc = wrCyc+6, tick seen at +4
    if (twoWrites) begin
      divInt = 14'd9; divFrac = 3'd5; divWe = 1'b1;
      @(negedge clk);                    // captured, cyc = wrCyc+7
    end else begin
      @(negedge clk);
    end
    writeDiv(3, 2);                      // captured, cyc = wrCyc+8
    while (nTk < 12) @(negedge clk);
    chk(tk[0] == wrCyc + 4, "R6 old first", tk[0], wrCyc + 4);
    chk(tk[1] == wrCyc + 9, twoWrites ? "R8 old kept" : "R6 old kept",
        tk[1], wrCyc + 9);
    t = wrCyc + 9;
    for (int k = 0; k < 10; k++) begin
      t += 3 + extra(k, 2);
      chk(tk[k + 2] == t, twoWrites ? "R8 last write" : "R6 new divisor",
          tk[k + 2], t);
    end
  endtask

  // R3: N=1 keeps tick high every cycle
  task automatic testFull();
    doReset();
    rec = 1'b1;
    writeDiv(1, 0);
    for (int i = 0; i < 16; i++) begin
      chk(tick == 1'b1, "R3 continuous tick", int'(tick), 1);
      @(negedge clk);
    end
  endtask

  initial begin
    testReset();
    runScenario(7, 0, 7, 6, "R3 integer spacing");
    runScenario(4, 3, 4, 17, "R4 fraction 3/8");
    runScenario(2, 7, 2, 17, "R4 fraction 7/8");
    runScenario(0, 0, 1, 10, "R5 zero as one");
    runScenario(16383, 0, 16383, 3, "R7 max divisor");
    testFull();
    testSwitch(1'b0);
    testSwitch(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule